// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as a single request output. Each line is fixed at build time as either edge-sensitive or level-sensitive. A captured request is held in a status register until software acknowledges it. An enable register masks the held requests, and the masked result is visible as a pending register. A vector register reports the lowest-numbered pending source, so a handler can find the source with one read.

Software changes the enable mask in one of two ways. It can write the whole mask, or it can set or clear chosen bits through two alias locations without a read-modify-write. The output to the processor is raised only when both bits of a two-bit master control register are set. The register port is a single-cycle write strobe with a word address. The read data is combinational from the addressed register.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and master registers read 0, the vector register reads 0xFFFFFFFF and irq_out is 0.
- R2: An input whose bit in EDGE_MASK is 1 sets its status bit one clock after a rising edge. The default EDGE_MASK is 0x0000FFFF, so inputs 0 to 15 are edge-sensitive. Holding that input high does not set the bit again after it is acknowledged.
- R3: An input whose bit in EDGE_MASK is 0 sets its status bit on every clock in which it is high. By default these are inputs 16 to 31. An acknowledge written while the input is still high leaves the bit set. An acknowledge written after the input has fallen clears the bit.
- R4: Writing to word offset 0x0C clears each status bit written as 1 and leaves the bits written as 0 unchanged. Writing 0xFFFFFFFF clears every held request.
- R5: Writing to offset 0x08 replaces the enable register, and reading offset 0x08 returns the value written.
- R6: A write to offset 0x10 sets the enable bits written as 1. A write to offset 0x14 clears the enable bits written as 1. Bits written as 0 are unchanged in both cases, and both offsets read 0.
- R7: Offset 0x00 reads the status register. Offset 0x04 reads status AND enable.
- R8: Offset 0x18 reads the index of the lowest-numbered pending bit. It reads 0xFFFFFFFF when no bit is pending.
- R9: Offset 0x1C holds two bits that read back as written: bit 0 is the global enable and bit 1 is the output enable. irq_out is 1 exactly when some pending bit is set and both of these bits are 1.
- R10: While the enable register is 0, irq_out stays 0 whatever the inputs do.
- R11: If an acknowledge and a new capture hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word address, byte address bits 4 to 2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two edge-sensitive inputs are raised together and then held high across an acknowledge. This separates edge capture from level capture and shows that an acknowledge clears only the bits written as 1. A level input is acknowledged once while still high and once after it has fallen; the first status bit stays set and the second clears. Enables are moved through the plain register and through both aliases so that the vector read changes between two pending sources, which shows that the lowest index is chosen. The master bits are walked through 01, 10 and 11, which separates the AND of the two bits from an OR. A directed case acknowledges a bit in the same cycle as its rising edge, and the bit must end up set.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared constants and the word-address decode for the interrupt
// controller. Assumes a 32-bit register port and at most 32 sources.
package irq_ctrl_pkg;

    localparam int DATA_W = 32;
    localparam int MSTR_W = 2;
    localparam int WADDR_W = 3;

    // Word address of each register; the software map depends on this order.
    typedef enum logic [WADDR_W-1:0] {
        RA_STATUS  = 3'd0,
        RA_PENDING = 3'd1,
        RA_ENABLE  = 3'd2,
        RA_ACK     = 3'd3,
        RA_SET_EN  = 3'd4,
        RA_CLR_EN  = 3'd5,
        RA_VECTOR  = 3'd6,
        RA_MASTER  = 3'd7
    } reg_addr_e;

    // Bit positions inside the master register.
    localparam int MSTR_GLOBAL = 0;
    localparam int MSTR_OUTPUT = 1;

endpackage

// File: rtl/irq_capture.sv
// Module: irq_capture
// Holds one status bit per source. Sources whose EDGE_MASK bit is 1 are
// captured on a rising edge, seen against a registered copy of the input.
// Sources whose bit is 0 are captured on every cycle the line is high.
// An acknowledge clears a bit, but a capture in the same cycle wins.
// Assumes irq_in is already synchronous to clk.
module irq_capture #(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] ack_vec,
    output logic [NUM_SRC-1:0] status
);

    logic [NUM_SRC-1:0] capture;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        if (EDGE_MASK[gi]) begin : g_edge
            logic line_q;

            // Keep last cycle's level of the line for rising-edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) line_q <= 1'b0;
                else        line_q <= irq_in[gi];
            end

            assign capture[gi] = irq_in[gi] & ~line_q;
        end else begin : g_level
            assign capture[gi] = irq_in[gi];
        end

        // Update the held request: acknowledge clears it, a new capture sets it.
        always_ff @(posedge clk) begin
            if (!rst_n) status[gi] <= 1'b0;
            else        status[gi] <= (status[gi] & ~ack_vec[gi]) | capture[gi];
        end
    end

    // R4: a bit acknowledged without a competing capture is clear next cycle.
    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_vec) |=> ((status & $past(ack_vec & ~capture)) == '0));

    // R2 and R3: a status bit only rises when a capture was seen for it.
    p_rise_needs_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(capture)) == '0));

    // R11: a capture always leaves its bit set, whatever the acknowledge did.
    p_capture_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|capture) |=> ((status & $past(capture)) == $past(capture)));

endmodule

// File: rtl/irq_enable_regs.sv
// Module: irq_enable_regs
// The enable mask and the two-bit master register. The mask can be written
// whole, or have chosen bits set or cleared through alias strobes. At most
// one strobe is active per cycle, since they come from one address decode.
module irq_enable_regs #(
    parameter int NUM_SRC = 32,
    parameter int MSTR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_enable,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic               wr_master,
    input  logic [NUM_SRC-1:0] wdata_src,
    input  logic [MSTR_W-1:0]  wdata_mstr,
    output logic [NUM_SRC-1:0] enable,
    output logic [MSTR_W-1:0]  master
);

    logic [NUM_SRC-1:0] enable_nxt;

    // Choose the next mask from whichever write form is active.
    always_comb begin
        enable_nxt = enable;
        if (wr_enable)   enable_nxt = wdata_src;
        else if (wr_set) enable_nxt = enable | wdata_src;
        else if (wr_clr) enable_nxt = enable & ~wdata_src;
    end

    // Register the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) enable <= '0;
        else        enable <= enable_nxt;
    end

    // Register the master control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         master <= '0;
        else if (wr_master) master <= wdata_mstr;
    end

    p_plain_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (enable == $past(wdata_src)));

    p_set_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((enable & $past(wdata_src)) == $past(wdata_src)
                    && (enable & ~$past(wdata_src)) == ($past(enable) & ~$past(wdata_src))));

    p_clr_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((enable & $past(wdata_src)) == '0
                    && (enable & ~$past(wdata_src)) == ($past(enable) & ~$past(wdata_src))));

    p_master_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_master |=> $stable(master));

endmodule

// File: rtl/irq_vector_enc.sv
// Module: irq_vector_enc
// Finds the lowest-numbered set bit of the pending vector and returns its
// index zero-extended to the data width, or all ones when nothing is pending.
// Purely combinational; the clock only serves the checks.
module irq_vector_enc #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pending,
    output logic               any_pending,
    output logic [DATA_W-1:0]  vector
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [IDX_W-1:0] low_idx;

    // Scan from the top down so the lowest set bit is the last one assigned.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i]) low_idx = IDX_W'(i);
        end
    end

    assign any_pending = |pending;
    assign vector      = any_pending ? DATA_W'(low_idx) : '1;

    // R8: the reported index is pending and no lower-numbered bit is.
    p_lowest_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|pending) |-> (pending[vector[IDX_W-1:0]]
                        && ((pending & ((NUM_SRC'(1) << vector[IDX_W-1:0]) - NUM_SRC'(1))) == '0)));

    // R8: nothing pending reads as all ones.
    p_empty_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> (vector == '1));

endmodule

// File: rtl/irq_ctrl.sv
// Module: irq_ctrl (top)
// Register port, request capture, enable masking, vector encoding and the
// gating of the processor request. The port takes a one-cycle write strobe
// with a word address and returns read data combinationally.
// Assumes NUM_SRC <= DATA_W.
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_wr,
    input  logic [4:2]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    reg_addr_e          addr_sel;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] ack_vec;
    logic [MSTR_W-1:0]  master;
    logic [DATA_W-1:0]  vector;
    logic               any_pending;

    assign addr_sel = reg_addr_e'(bus_addr);

    // Turn a write to the acknowledge location into a clear vector.
    assign ack_vec = (bus_wr && addr_sel == RA_ACK) ? bus_wdata[NUM_SRC-1:0] : '0;

    irq_capture #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .ack_vec (ack_vec),
        .status  (status)
    );

    irq_enable_regs #(
        .NUM_SRC (NUM_SRC),
        .MSTR_W  (MSTR_W)
    ) u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_enable  (bus_wr && addr_sel == RA_ENABLE),
        .wr_set     (bus_wr && addr_sel == RA_SET_EN),
        .wr_clr     (bus_wr && addr_sel == RA_CLR_EN),
        .wr_master  (bus_wr && addr_sel == RA_MASTER),
        .wdata_src  (bus_wdata[NUM_SRC-1:0]),
        .wdata_mstr (bus_wdata[MSTR_W-1:0]),
        .enable     (enable),
        .master     (master)
    );

    assign pending = status & enable;

    irq_vector_enc #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) u_vector (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending     (pending),
        .any_pending (any_pending),
        .vector      (vector)
    );

    // Raise the processor request only when both master bits allow it.
    assign irq_out = any_pending & master[MSTR_GLOBAL] & master[MSTR_OUTPUT];

    // Select the read data for the addressed register; aliases read zero.
    always_comb begin
        unique case (addr_sel)
            RA_STATUS:  bus_rdata = DATA_W'(status);
            RA_PENDING: bus_rdata = DATA_W'(pending);
            RA_ENABLE:  bus_rdata = DATA_W'(enable);
            RA_VECTOR:  bus_rdata = vector;
            RA_MASTER:  bus_rdata = DATA_W'(master);
            default:    bus_rdata = '0;
        endcase
    end

    // R10: an all-zero enable mask keeps the request low.
    p_mask_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq_out);

    // R9: the request never rises while either master bit is clear.
    p_master_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (master != 2'b11) |-> !irq_out);

endmodule

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for irq_ctrl: a table walked by one loop, then directed tests
// for the same-cycle acknowledge and for reset.
module irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [4:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Step kinds: 0 write, 1 read and compare, 2 drive irq_in, 3 compare irq_out.
    // Fields: {kind[1:0], byte address[4:0], data[31:0], requirement[3:0]}.
    localparam int NSTEP = 47;
    localparam logic [42:0] STEPS [NSTEP] = '{
        {2'd1, 5'h00, 32'h0000_0000, 4'd1},   // R1 status
        {2'd1, 5'h18, 32'hFFFF_FFFF, 4'd1},   // R1 vector
        {2'd1, 5'h1C, 32'h0000_0000, 4'd1},   // R1 master
        {2'd3, 5'h00, 32'h0000_0000, 4'd1},   // R1 irq_out
        {2'd0, 5'h1C, 32'h0000_0003, 4'd9},   // R9 master on
        {2'd1, 5'h1C, 32'h0000_0003, 4'd9},   // R9 read back
        {2'd2, 5'h00, 32'h0000_0030, 4'd2},   // R2 edges on 4 and 5
        {2'd1, 5'h00, 32'h0000_0030, 4'd2},   // R2 captured
        {2'd1, 5'h04, 32'h0000_0000, 4'd7},   // R7 masked
        {2'd3, 5'h00, 32'h0000_0000, 4'd10},  // R10 no request
        {2'd0, 5'h08, 32'h0000_0020, 4'd5},   // R5 write mask
        {2'd1, 5'h08, 32'h0000_0020, 4'd5},   // R5 read back
        {2'd1, 5'h04, 32'h0000_0020, 4'd7},   // R7 pending
        {2'd1, 5'h18, 32'h0000_0005, 4'd8},   // R8 single
        {2'd3, 5'h00, 32'h0000_0001, 4'd9},   // R9 request up
        {2'd0, 5'h10, 32'h0000_0010, 4'd6},   // R6 set alias
        {2'd1, 5'h08, 32'h0000_0030, 4'd6},   // R6 ored
        {2'd1, 5'h18, 32'h0000_0004, 4'd8},   // R8 lowest wins
        {2'd1, 5'h10, 32'h0000_0000, 4'd6},   // R6 alias reads 0
        {2'd0, 5'h14, 32'h0000_0020, 4'd6},   // R6 clear alias
        {2'd1, 5'h08, 32'h0000_0010, 4'd6},   // R6 cleared
        {2'd1, 5'h14, 32'h0000_0000, 4'd6},   // R6 alias reads 0
        {2'd0, 5'h0C, 32'h0000_0010, 4'd4},   // R4 ack bit 4, line held
        {2'd1, 5'h00, 32'h0000_0020, 4'd2},   // R2 no relatch, R4 bit 5 kept
        {2'd1, 5'h04, 32'h0000_0000, 4'd7},   // R7
        {2'd3, 5'h00, 32'h0000_0000, 4'd9},   // R9 request down
        {2'd2, 5'h00, 32'h0000_0000, 4'd3},   // R3 lines low
        {2'd2, 5'h00, 32'h0001_0000, 4'd3},   // R3 level 16 high
        {2'd1, 5'h00, 32'h0001_0020, 4'd3},   // R3 captured
        {2'd0, 5'h0C, 32'h0001_0000, 4'd3},   // R3 ack while high
        {2'd1, 5'h00, 32'h0001_0020, 4'd3},   // R3 relatched
        {2'd2, 5'h00, 32'h0000_0000, 4'd3},   // R3 line falls
        {2'd0, 5'h0C, 32'h0001_0000, 4'd3},   // R3 ack after fall
        {2'd1, 5'h00, 32'h0000_0020, 4'd3},   // R3 cleared
        {2'd0, 5'h1C, 32'h0000_0001, 4'd9},   // R9 only bit 0
        {2'd0, 5'h08, 32'h0000_0020, 4'd9},   // R9 enable 5
        {2'd1, 5'h04, 32'h0000_0020, 4'd7},   // R7
        {2'd3, 5'h00, 32'h0000_0000, 4'd9},   // R9 low with 01
        {2'd0, 5'h1C, 32'h0000_0002, 4'd9},   // R9 only bit 1
        {2'd3, 5'h00, 32'h0000_0000, 4'd9},   // R9 low with 10
        {2'd0, 5'h1C, 32'h0000_0003, 4'd9},   // R9 both
        {2'd3, 5'h00, 32'h0000_0001, 4'd9},   // R9 high with 11
        {2'd0, 5'h08, 32'h0000_0000, 4'd10},  // R10 mask all
        {2'd3, 5'h00, 32'h0000_0000, 4'd10},  // R10 request low
        {2'd1, 5'h18, 32'hFFFF_FFFF, 4'd8},   // R8 none pending
        {2'd0, 5'h0C, 32'hFFFF_FFFF, 4'd4},   // R4 ack all
        {2'd1, 5'h00, 32'h0000_0000, 4'd4}    // R4 all clear
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Start a new cycle at the falling edge with the write strobe dropped.
    task automatic next_cycle();
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NSTEP; s++) begin
            logic [1:0]  kind;
            logic [4:0]  addr;
            logic [31:0] data;
            int          req;
            kind = STEPS[s][42:41];
            addr = STEPS[s][40:36];
            data = STEPS[s][35:4];
            req  = int'(STEPS[s][3:0]);
            next_cycle();
            case (kind)
                2'd0: begin
                    bus_addr = addr[4:2]; bus_wdata = data; bus_wr = 1'b1;
                end
                2'd1: begin
                    bus_addr = addr[4:2];
                    #1 check(req, bus_rdata, data);
                end
                2'd2: irq_in = data;
                default: #1 check(req, {31'b0, irq_out}, data);
            endcase
        end

        // R11: acknowledge and rising edge on bit 7 in the same cycle.
        next_cycle();
        irq_in = 32'h0000_0080;
        bus_addr = 3'd3; bus_wdata = 32'h0000_0080; bus_wr = 1'b1;
        next_cycle();
        bus_addr = 3'd0;
        #1 check(11, bus_rdata, 32'h0000_0080);   // R11 capture wins

        // R1: reset with state loaded clears everything.
        next_cycle();
        bus_addr = 3'd2; bus_wdata = 32'h0000_00FF; bus_wr = 1'b1;
        next_cycle();
        #1 check(9, {31'b0, irq_out}, 32'h1);     // R9 request before reset
        irq_in = '0;
        rst_n = 1'b0;
        next_cycle();
        rst_n = 1'b1;
        bus_addr = 3'd0;
        #1 check(1, bus_rdata, 32'h0);            // R1 status
        bus_addr = 3'd2;
        #1 check(1, bus_rdata, 32'h0);            // R1 enable
        bus_addr = 3'd7;
        #1 check(1, bus_rdata, 32'h0);            // R1 master
        bus_addr = 3'd6;
        #1 check(1, bus_rdata, 32'hFFFF_FFFF);    // R1 vector
        check(1, {31'b0, irq_out}, 32'h0);        // R1 irq_out

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule